// File: doc/BRIEF.md
# Vectored Restart Interrupt Controller

This block decides which interrupt a small 8-bit processor core takes at the next instruction boundary. There are five sources. One is a non-maskable trap. Three are restart lines, each with its own mask bit. The last is a general request. The core raises a sampling strobe on the clock before the last clock of each instruction, and keeps it high while it is in hold or halt. On that strobe the block picks the highest-ranking source that may be taken. One cycle later it reports the acceptance.

A trap or restart source produces an internally generated restart vector, so the core fetches no opcode. A general request instead produces an acknowledge pulse and a program-counter hold pulse, and external logic places the opcode on the bus. Software controls the block in four ways:
- enable and disable commands for the interrupt-enable flag;
- a set-mask write that updates the masks, clears the latched top restart request and drives a serial output bit;
- a combinational read-mask status byte, which also carries the serial input pin.

Top module: `restart_irq_ctrl`

## Requirements
- R1: After reset the masks are all set (rim_o = 0x07 with sid_i low). The enable flag, sod_o, both request latches and all acceptance outputs are 0.
- R2: Sources are evaluated only at a clock edge where sample_i is 1. The acceptance outputs pulse for exactly the following cycle. With sample_i low, no acceptance occurs whatever the inputs.
- R3: The fixed priority, highest first, is trap, restart line 7.5, restart line 6.5, restart line 5.5, general request.
- R4: The trap ignores masks and the enable flag. It is taken only after a rising edge, while the input is still high at the sampling edge. A trap that drops before sampling is lost. A trap held high is taken once per rising edge.
- R5: A set-mask write with data bit 3 set loads data bits [2:0] into the masks (bit 0 line 5.5, bit 1 line 6.5, bit 2 line 7.5, 1 = masked). With bit 3 clear the masks are unchanged. A masked restart line is never accepted.
- R6: Line 7.5 is captured on a rising edge whether or not it is masked. The capture holds until that line is accepted or a set-mask write has data bit 4 set. Lines 5.5 and 6.5 and the general request are level sensitive.
- R7: An accepted trap or restart line raises vec_valid_o with vec_o = 0x0024 for the trap, 0x002C for 5.5, 0x0034 for 6.5 and 0x003C for 7.5. Otherwise vec_o is 0.
- R8: An accepted general request raises inta_o and pc_hold_o for one cycle, with vec_valid_o low.
- R9: ei_i sets the enable flag and di_i clears it. Acceptance of any maskable source clears it, and this clear wins over ei_i in the same cycle. Trap acceptance leaves the flag unchanged. Maskable sources are taken only while the flag is set.
- R10: rim_o holds the masks in bits [2:0], the enable flag in bit 3, the pending 5.5, 6.5 and 7.5 requests in bits 4, 5 and 6, and sid_i in bit 7.
- R11: A set-mask write with data bit 6 set copies data bit 7 to sod_o. With bit 6 clear, sod_o holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 1 | Instruction-boundary or hold/halt sampling strobe |
| trap_i | input | 1 | Non-maskable trap request |
| rst55_i | input | 1 | Restart line 5.5, level |
| rst65_i | input | 1 | Restart line 6.5, level |
| rst75_i | input | 1 | Restart line 7.5, rising edge |
| intr_i | input | 1 | General interrupt request, level |
| ei_i | input | 1 | Set the enable flag |
| di_i | input | 1 | Clear the enable flag |
| sim_wr_i | input | 1 | Set-mask write strobe |
| sim_data_i | input | 8 | Set-mask data byte |
| sid_i | input | 1 | Serial input pin |
| accept_o | output | 1 | Interrupt accepted (one cycle) |
| vec_valid_o | output | 1 | Internal restart vector valid |
| vec_o | output | VEC_W | Restart vector address |
| inta_o | output | 1 | Acknowledge strobe for the general request |
| pc_hold_o | output | 1 | Inhibit program-counter increment |
| rim_o | output | 8 | Read-mask status byte |
| sod_o | output | 1 | Serial output pin |

## Verification
A wrong mask or enable bit is visible at once in rim_o, and at the next sampling strobe it shows as a missing or extra acceptance. A request latch that sticks or drops shows in rim_o bit 6 straight after the edge. For the trap, it shows as an acceptance on the second sample that should not occur. The bench sweeps every combination of the five request inputs under an open configuration, and every mask pattern with the enable flag both set and cleared. From each case it computes the winner and checks the vector or acknowledge one cycle after the strobe.

// File: rtl/restart_irq_pkg.sv
package restart_irq_pkg;
  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_TRAP = 3'd1,
    SRC_R55  = 3'd2,
    SRC_R65  = 3'd3,
    SRC_R75  = 3'd4,
    SRC_INTR = 3'd5
  } irq_src_e;

  localparam int N_RST      = 3;
  localparam int SM_MSE_BIT = 3;
  localparam int SM_CLR_BIT = 4;
  localparam int SM_SOE_BIT = 6;
  localparam int SM_SOD_BIT = 7;

  // vector slot: trap 0, restart lines 1..N_RST
  function automatic int src_slot(irq_src_e s);
    case (s)
      SRC_R55: return 1;
      SRC_R65: return 2;
      SRC_R75: return 3;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/restart_irq_edge.sv
module restart_irq_edge #(
  parameter bit HOLD_LEVEL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_i,
  input  logic clr_i,
  output logic pend_o
);
  logic prev_q, lat_q, lat_d, rise;

  assign rise = in_i & ~prev_q;

  generate
    if (HOLD_LEVEL) begin : g_hold
      assign lat_d = (lat_q | rise) & in_i & ~clr_i;
    end else begin : g_sticky
      assign lat_d = (lat_q | rise) & ~clr_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      lat_q  <= 1'b0;
    end else begin
      prev_q <= in_i;
      lat_q  <= lat_d;
    end
  end

  assign pend_o = lat_q;
endmodule

// File: rtl/restart_irq_regs.sv
module restart_irq_regs
  import restart_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ei_i,
  input  logic             di_i,
  input  logic             ie_clr_i,
  input  logic             sim_wr_i,
  input  logic [7:0]       sim_data_i,
  output logic [N_RST-1:0] mask_o,
  output logic             ie_o,
  output logic             sod_o
);
  logic [N_RST-1:0] mask_q;
  logic             ie_q, sod_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q <= 1'b0;
    end else if (ie_clr_i || di_i) begin
      ie_q <= 1'b0;
    end else if (ei_i) begin
      ie_q <= 1'b1;
    end
  end

  generate
    for (genvar i = 0; i < N_RST; i++) begin : g_mask
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) mask_q[i] <= 1'b1;
        else if (sim_wr_i && sim_data_i[SM_MSE_BIT]) mask_q[i] <= sim_data_i[i];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sod_q <= 1'b0;
    else if (sim_wr_i && sim_data_i[SM_SOE_BIT]) sod_q <= sim_data_i[SM_SOD_BIT];
  end

  assign mask_o = mask_q;
  assign ie_o   = ie_q;
  assign sod_o  = sod_q;
endmodule

// File: rtl/restart_irq_arb.sv
module restart_irq_arb
  import restart_irq_pkg::*;
(
  input  logic             trap_i,
  input  logic [N_RST-1:0] rst_pend_i,
  input  logic [N_RST-1:0] mask_i,
  input  logic             ie_i,
  input  logic             intr_i,
  output irq_src_e         src_o
);
  logic [N_RST-1:0] live;
  assign live = rst_pend_i & ~mask_i & {N_RST{ie_i}};

  always_comb begin
    src_o = SRC_NONE;
    if (intr_i && ie_i) src_o = SRC_INTR;
    // ascending scan: higher line overrides lower
    for (int i = 0; i < N_RST; i++) begin
      if (live[i]) src_o = irq_src_e'(int'(SRC_R55) + i);
    end
    if (trap_i) src_o = SRC_TRAP;
  end
endmodule

// File: rtl/restart_irq_ctrl.sv
module restart_irq_ctrl
  import restart_irq_pkg::*;
#(
  parameter int VEC_W    = 16,
  parameter int VEC_BASE = 'h24,
  parameter int VEC_STEP = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sample_i,
  input  logic             trap_i,
  input  logic             rst55_i,
  input  logic             rst65_i,
  input  logic             rst75_i,
  input  logic             intr_i,
  input  logic             ei_i,
  input  logic             di_i,
  input  logic             sim_wr_i,
  input  logic [7:0]       sim_data_i,
  input  logic             sid_i,
  output logic             accept_o,
  output logic             vec_valid_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             inta_o,
  output logic             pc_hold_o,
  output logic [7:0]       rim_o,
  output logic             sod_o
);
  logic             trap_pend, r75_pend;
  logic [N_RST-1:0] rst_pend, mask;
  logic             ie;
  irq_src_e         src;
  logic             take, take_trap, take_r75, take_mask;
  logic             r75_clr;

  logic             accept_q, vvalid_q, inta_q;
  logic [VEC_W-1:0] vec_q, vec_d;

  restart_irq_edge #(.HOLD_LEVEL(1'b1)) u_trap (
    .clk_i (clk_i), .rst_ni(rst_ni), .in_i(trap_i),
    .clr_i (take_trap), .pend_o(trap_pend)
  );

  restart_irq_edge #(.HOLD_LEVEL(1'b0)) u_r75 (
    .clk_i (clk_i), .rst_ni(rst_ni), .in_i(rst75_i),
    .clr_i (r75_clr), .pend_o(r75_pend)
  );

  assign rst_pend = {r75_pend, rst65_i, rst55_i};

  restart_irq_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ei_i      (ei_i),
    .di_i      (di_i),
    .ie_clr_i  (take_mask),
    .sim_wr_i  (sim_wr_i),
    .sim_data_i(sim_data_i),
    .mask_o    (mask),
    .ie_o      (ie),
    .sod_o     (sod_o)
  );

  restart_irq_arb u_arb (
    .trap_i    (trap_pend),
    .rst_pend_i(rst_pend),
    .mask_i    (mask),
    .ie_i      (ie),
    .intr_i    (intr_i),
    .src_o     (src)
  );

  assign take      = sample_i && (src != SRC_NONE);
  assign take_trap = take && (src == SRC_TRAP);
  assign take_r75  = take && (src == SRC_R75);
  assign take_mask = take && (src != SRC_TRAP);
  assign r75_clr   = take_r75 || (sim_wr_i && sim_data_i[SM_CLR_BIT]);

  assign vec_d = VEC_W'(VEC_BASE + VEC_STEP * src_slot(src));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      accept_q <= 1'b0;
      vvalid_q <= 1'b0;
      inta_q   <= 1'b0;
      vec_q    <= '0;
    end else begin
      accept_q <= take;
      vvalid_q <= take && (src != SRC_INTR);
      inta_q   <= take && (src == SRC_INTR);
      vec_q    <= (take && (src != SRC_INTR)) ? vec_d : '0;
    end
  end

  assign accept_o    = accept_q;
  assign vec_valid_o = vvalid_q;
  assign vec_o       = vec_q;
  assign inta_o      = inta_q;
  assign pc_hold_o   = inta_q;
  assign rim_o       = {sid_i, rst_pend, ie, mask};
endmodule

// File: rtl/restart_irq_chk.sv
module restart_irq_chk #(
  parameter int VEC_W    = 16,
  parameter int VEC_BASE = 'h24,
  parameter int VEC_STEP = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sample_i,
  input logic             sim_wr_i,
  input logic [7:0]       sim_data_i,
  input logic             accept_o,
  input logic             vec_valid_o,
  input logic [VEC_W-1:0] vec_o,
  input logic             inta_o,
  input logic             pc_hold_o,
  input logic [7:0]       rim_o,
  input logic             sod_o
);
  localparam logic [VEC_W-1:0] TRAP_V = VEC_W'(VEC_BASE);
  localparam logic [VEC_W-1:0] R75_V  = VEC_W'(VEC_BASE + 3 * VEC_STEP);

  a_r2_accept_after_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> $past(sample_i));

  a_r7_vec_with_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> accept_o);

  a_r8_ack_shape: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inta_o |-> (accept_o && pc_hold_o && !vec_valid_o));

  a_r9_enable_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && !(vec_valid_o && vec_o == TRAP_V)) |-> !rim_o[3]);

  a_r9_enable_needed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && !(vec_valid_o && vec_o == TRAP_V)) |-> $past(rim_o[3]));

  a_r5_mask_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(sim_wr_i && sim_data_i[3])) |-> rim_o[2:0] == $past(sim_data_i[2:0]));

  a_r5_masked_r75: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && vec_valid_o && vec_o == R75_V) |-> !$past(rim_o[2]));

  a_r11_sod_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(sim_wr_i && sim_data_i[6])) |-> sod_o == $past(sim_data_i[7]));
endmodule

bind restart_irq_ctrl restart_irq_chk #(
  .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sample_i   (sample_i),
  .sim_wr_i   (sim_wr_i),
  .sim_data_i (sim_data_i),
  .accept_o   (accept_o),
  .vec_valid_o(vec_valid_o),
  .vec_o      (vec_o),
  .inta_o     (inta_o),
  .pc_hold_o  (pc_hold_o),
  .rim_o      (rim_o),
  .sod_o      (sod_o)
);

// File: tb/sim_restart_irq_ctrl.sv
`timescale 1ns/1ps
module sim_restart_irq_ctrl;
  logic        clk_i = 0, rst_ni = 0;
  logic        sample_i = 0, trap_i = 0, rst55_i = 0, rst65_i = 0, rst75_i = 0, intr_i = 0;
  logic        ei_i = 0, di_i = 0, sim_wr_i = 0, sid_i = 0;
  logic [7:0]  sim_data_i = 0;
  logic        accept_o, vec_valid_o, inta_o, pc_hold_o, sod_o;
  logic [15:0] vec_o;
  logic [7:0]  rim_o;
  int errors = 0, checks = 0;

  always #2 clk_i = ~clk_i;

  restart_irq_ctrl u0 (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_mask(logic [7:0] d);
    @(negedge clk_i); sim_wr_i = 1; sim_data_i = d;
    @(negedge clk_i); sim_wr_i = 0; sim_data_i = 0;
  endtask

  task automatic set_ie(bit on);
    @(negedge clk_i); ei_i = on; di_i = !on;
    @(negedge clk_i); ei_i = 0; di_i = 0;
  endtask

  // clear inputs and latches, then configure
  task automatic prep(bit ie, logic [2:0] m);
    @(negedge clk_i);
    {trap_i, rst75_i, rst65_i, rst55_i, intr_i} = 0;
    set_mask(8'h18 | {5'b0, m});
    set_ie(ie);
  endtask

  task automatic do_sample();
    sample_i = 1;
    @(negedge clk_i); sample_i = 0;
  endtask

  // -1 none, -2 general request, otherwise vector
  function automatic int winner(bit t, bit r75, bit r65, bit r55, bit ir, bit ie, logic [2:0] m);
    if (t) return 'h24;
    if (ie && r75 && !m[2]) return 'h3C;
    if (ie && r65 && !m[1]) return 'h34;
    if (ie && r55 && !m[0]) return 'h2C;
    if (ie && ir) return -2;
    return -1;
  endfunction

  task automatic chk_out(string req, int w);
    chk(req, accept_o, w != -1);
    chk(req, vec_valid_o, w >= 0);
    chk(req, vec_o, (w >= 0) ? w : 0);
    chk(req, inta_o, w == -2);
    chk(req, pc_hold_o, w == -2);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1", rim_o, 8'h07);
    chk("R1", sod_o, 0);
    chk_out("R1", -1);

    // R3 R7 R8: sweep all request combinations, open config
    for (int c = 0; c < 32; c++) begin
      prep(1, 3'b000);
      {trap_i, rst75_i, rst65_i, rst55_i, intr_i} = c[4:0];
      @(negedge clk_i);
      do_sample();
      chk_out("R3", winner(c[4], c[3], c[2], c[1], c[0], 1, 3'b000));
      // R9: maskable acceptance clears enable, trap keeps it
      chk("R9", rim_o[3], (c[4] || c[3:0] == 0) ? 1 : 0);
    end

    // R5 R9: all masks with enable on and off, maskable lines all high
    for (int e = 0; e < 2; e++) begin
      for (int m = 0; m < 8; m++) begin
        prep(e[0], m[2:0]);
        chk("R10", rim_o[3:0], {e[0], m[2:0]});
        {rst75_i, rst65_i, rst55_i, intr_i} = 4'hF;
        @(negedge clk_i);
        do_sample();
        chk_out("R5", winner(0, 1, 1, 1, 1, e[0], m[2:0]));
      end
    end

    // R2: no strobe, no acceptance
    prep(1, 3'b000);
    intr_i = 1; rst55_i = 1;
    repeat (4) @(negedge clk_i);
    chk_out("R2", -1);
    do_sample();
    chk_out("R2", 'h2C);
    @(negedge clk_i);
    chk_out("R2", -1);

    // R4: trap held high is taken once; dropped trap is lost
    prep(0, 3'b111);
    trap_i = 1; @(negedge clk_i);
    do_sample(); chk_out("R4", 'h24);
    do_sample(); chk_out("R4", -1);
    trap_i = 0; @(negedge clk_i);
    trap_i = 1; @(negedge clk_i);
    trap_i = 0; @(negedge clk_i);
    do_sample(); chk_out("R4", -1);

    // R6: 7.5 latched while masked, held, then taken and cleared
    prep(1, 3'b100);
    rst75_i = 1; @(negedge clk_i);
    rst75_i = 0; @(negedge clk_i);
    chk("R6", rim_o[6], 1);
    do_sample(); chk_out("R6", -1);
    set_mask(8'h08);
    chk("R6", rim_o[6], 1);
    do_sample(); chk_out("R6", 'h3C);
    chk("R6", rim_o[6], 0);
    // R6: cleared by set-mask bit 4; masks untouched without bit 3
    rst75_i = 1; @(negedge clk_i); rst75_i = 0;
    chk("R6", rim_o[6], 1);
    set_mask(8'h15);
    chk("R6", rim_o[6], 0);
    chk("R5", rim_o[2:0], 3'b000);
    // R6: 5.5 level follows the pin
    rst55_i = 1; #0.1; chk("R6", rim_o[4], 1);
    rst55_i = 0; #0.1; chk("R6", rim_o[4], 0);

    // R9: acceptance clear wins over ei in the same cycle
    prep(1, 3'b000);
    intr_i = 1; @(negedge clk_i);
    sample_i = 1; ei_i = 1;
    @(negedge clk_i); sample_i = 0; ei_i = 0;
    chk_out("R9", -2);
    chk("R9", rim_o[3], 0);
    intr_i = 0;

    // R11 R10: serial output and input
    set_mask(8'hC0); chk("R11", sod_o, 1);
    set_mask(8'h80); chk("R11", sod_o, 1);
    set_mask(8'h40); chk("R11", sod_o, 0);
    sid_i = 1; #0.1; chk("R10", rim_o[7], 1);
    sid_i = 0; #0.1; chk("R10", rim_o[7], 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule